// File: doc/BRIEF.md
# Data Bus Pattern Tester

This block checks the data lines of a 64-bit memory path for bits that are stuck, shorted to a neighbour, or left floating. A start pulse latches a target word address. For each stimulus word in a fixed series, the tester writes the word to the target. It then writes a fixed filler word to the word address just above the target, which drives every data line to a different level. Only then does it read the target back, exactly once, and compare the single returned value with the word it wrote.

The series has twelve words. The first six are stripes of alternating ones and zeros with run lengths 1, 2, 4, 8, 16 and 32 bits. The last six are the bitwise inverses of the first six, taken in reverse order. Across the series, every pair of data lines is driven to opposite levels at least once, in both polarities. All twelve words are always tried. A pass flag is produced at the end. The address, the expected word and the returned word of the first mismatch are kept for inspection. When one byte lane floats, the filler byte shows up in that lane of the captured value.

The memory port has no backpressure. A request is taken in the cycle it is raised. A read answers with a valid strobe after any number of cycles, and the tester issues nothing while it waits for that strobe.

Top module: `databus_tester`

## Requirements
- R1: Out of reset, busy, done, pass and mem_req are all low, and the three failure-record outputs are zero.
- R2: For each stimulus word there are exactly three requests, in consecutive cycles: a write of the word to the target address T, then a write of the filler (default 64'h0123456789ABCDEF) to T+1, then a single read of T.
- R3: Stimulus word n for n = 0..5 has bit b equal to bit n of the binary bit index b (word 0 = 64'hAAAAAAAAAAAAAAAA, word 5 = 64'hFFFFFFFF00000000). Word n for n = 6..11 is the bitwise inverse of word 11-n (word 6 = 64'h00000000FFFFFFFF, word 11 = 64'h5555555555555555). The words are used in order 0 to 11.
- R4: After a read request, no request is issued until mem_rvalid has been seen. The comparison uses the mem_rdata of the cycle in which mem_rvalid is high, for any read latency of one or more cycles.
- R5: A start clears pass. If all twelve returned words match, pass is high from the cycle after done until the next start.
- R6: A mismatch on any word leaves pass low, and all twelve words are still run (36 requests in total).
- R7: The first mismatch records T, the expected word and the returned word on fail_addr, fail_expected and fail_actual. Later mismatches leave the record unchanged. A start clears the record to zero.
- R8: done is a single-cycle pulse after the twelfth comparison. busy is high from the cycle after the start cycle up to and including the done cycle, and low in the cycle after it.
- R9: A start pulse while busy is high has no effect: there is still one done pulse and exactly 36 requests for the run.
- R10: T is taken from target_addr in the start cycle and held for the whole run. The filler address is T+1 modulo 2^ADDR_W, so the all-ones target sends the filler to address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| target_addr | input | ADDR_W | Word address under test, latched at start |
| mem_req | output | 1 | Memory request, one access per high cycle |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | All words matched in the last run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_expected | output | DATA_W | Word written at the first mismatch |
| fail_actual | output | DATA_W | Word returned at the first mismatch |

## Verification
The tester runs against a clean memory model at read latencies of one and four cycles, and must pass both with the exact request order. The one-cycle case checks the back-to-back access order. The long latency shows whether the compare waits for the strobe: a stale read word from the previous stimulus would fail a clean memory. A model in which one byte lane floats returns the last bus value, the filler byte, in that lane. This separates a tester that inserts the filler write from one that does not, and it also checks that the first record is not overwritten when every word fails. A high-bit stuck-at-one fault first fails on word 6, which checks the pattern order and the record contents. Further runs cover a restart that clears the record, start pulses in mid-run, and a wrap of the filler address from the all-ones target.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WPAT  = 3'd1,
    ST_WFIL  = 3'd2,
    ST_RREQ  = 3'd3,
    ST_RWAIT = 3'd4,
    ST_FIN   = 3'd5
  } dbt_state_e;

  // One stripe word per power of two below the data width, plus inverses.
  function automatic int stim_count(input int data_w);
    return 2 * $clog2(data_w);
  endfunction

  function automatic int idx_width(input int data_w);
    return $clog2(stim_count(data_w));
  endfunction

endpackage

// File: rtl/dbt_pattern_gen.sv
module dbt_pattern_gen #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = dbt_pkg::idx_width(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] pattern
);
  localparam int NHALF = $clog2(DATA_W);
  localparam int NSTIM = 2 * NHALF;

  // Stripe word: bit b takes bit k of its own index.
  function automatic logic [DATA_W-1:0] stripe(input int k);
    logic [DATA_W-1:0] v;
    for (int b = 0; b < DATA_W; b++) begin
      v[b] = ((b >> k) & 1) != 0;
    end
    return v;
  endfunction

  logic [DATA_W-1:0] half_q [NHALF];

  for (genvar k = 0; k < NHALF; k++) begin : g_stripe
    assign half_q[k] = stripe(k);
  end

  always_comb begin
    pattern = '0;
    for (int j = 0; j < NHALF; j++) begin
      if (idx == IDX_W'(j))           pattern = half_q[j];
      if (idx == IDX_W'(NSTIM-1-j))   pattern = ~half_q[j];
    end
  end

endmodule

// File: rtl/dbt_seq.sv
module dbt_seq
  import dbt_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter int              DATA_W = 64,
  parameter logic [DATA_W-1:0] FILLER = 64'h0123456789ABCDEF,
  parameter int              IDX_W  = idx_width(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic [DATA_W-1:0] pattern,
  input  logic              mem_rvalid,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] tgt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              start_evt,
  output logic              pat_wr_evt,
  output logic              fill_wr_evt,
  output logic              rd_evt,
  output logic              cmp_evt,
  output logic              busy,
  output logic              done
);
  localparam int NSTIM = stim_count(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSTIM - 1);

  dbt_state_e state_q, state_d;

  function automatic logic [ADDR_W-1:0] neighbour(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  assign start_evt   = (state_q == ST_IDLE) && start;
  assign pat_wr_evt  = (state_q == ST_WPAT);
  assign fill_wr_evt = (state_q == ST_WFIL);
  assign rd_evt      = (state_q == ST_RREQ);
  assign cmp_evt     = (state_q == ST_RWAIT) && mem_rvalid;
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_WPAT;
      ST_WPAT:  state_d = ST_WFIL;
      ST_WFIL:  state_d = ST_RREQ;
      ST_RREQ:  state_d = ST_RWAIT;
      ST_RWAIT: if (mem_rvalid) state_d = (idx == LAST_IDX) ? ST_FIN : ST_WPAT;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx     <= '0;
      tgt     <= '0;
    end else begin
      state_q <= state_d;
      if (start_evt) begin
        idx <= '0;
        tgt <= target_addr;
      end else if (cmp_evt && idx != LAST_IDX) begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    mem_req   = pat_wr_evt || fill_wr_evt || rd_evt;
    mem_we    = pat_wr_evt || fill_wr_evt;
    mem_addr  = fill_wr_evt ? neighbour(tgt) : tgt;
    mem_wdata = pat_wr_evt ? pattern : (fill_wr_evt ? FILLER : '0);
  end

  // R2: filler write directly follows each stimulus write
  p_fill_follows_pat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pat_wr_evt |=> (fill_wr_evt && mem_req && mem_we && mem_wdata == FILLER));

  // R2: the single read goes back to the address just below the filler
  p_read_after_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr_evt |=> (mem_req && !mem_we && ADDR_W'(mem_addr + 1'b1) == $past(mem_addr)));

  // R4: bus stays quiet after the read request
  p_quiet_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> !mem_req);

  // R3: stimulus index stays inside the series
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= LAST_IDX));

  // R8: done lasts one cycle and ends the run
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9: a run cannot be cut short or restarted
  p_run_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(tgt)));

endmodule

// File: rtl/dbt_capture.sv
module dbt_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmp_evt,
  input  logic              fin_evt,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [DATA_W-1:0] expected,
  input  logic [DATA_W-1:0] actual,
  output logic              mis_evt,
  output logic              seen,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_expected,
  output logic [DATA_W-1:0] fail_actual
);
  function automatic logic differs(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return |(a ^ b);
  endfunction

  logic first_evt;

  assign mis_evt   = cmp_evt && differs(expected, actual);
  assign first_evt = mis_evt && !seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen          <= 1'b0;
      pass          <= 1'b0;
      fail_addr     <= '0;
      fail_expected <= '0;
      fail_actual   <= '0;
    end else if (clr) begin
      seen          <= 1'b0;
      pass          <= 1'b0;
      fail_addr     <= '0;
      fail_expected <= '0;
      fail_actual   <= '0;
    end else begin
      if (first_evt) begin
        seen          <= 1'b1;
        fail_addr     <= tgt;
        fail_expected <= expected;
        fail_actual   <= actual;
      end
      if (fin_evt) pass <= !seen;
    end
  end

  // R7: first record is never overwritten within a run
  p_hold_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !clr) |=> ($stable(fail_addr) && $stable(fail_expected) && $stable(fail_actual)));

  // R5: a start drops pass
  p_pass_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pass);

  // R6: once a mismatch is seen pass stays low
  p_no_pass_after_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !clr) |=> !pass);

  // R7: record is cleared on start
  p_record_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!seen && fail_expected == '0 && fail_actual == '0));

endmodule

// File: rtl/databus_tester.sv
module databus_tester
  import dbt_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 64,
  parameter logic [DATA_W-1:0] FILLER = 64'h0123456789ABCDEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] target_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_expected,
  output logic [DATA_W-1:0] fail_actual
);
  localparam int IDX_W = idx_width(DATA_W);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tgt;
  logic [DATA_W-1:0] pattern;
  logic start_evt, pat_wr_evt, fill_wr_evt, rd_evt, cmp_evt;
  logic mis_evt, seen;

  dbt_pattern_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pat (
    .idx     (idx),
    .pattern (pattern)
  );

  dbt_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILLER(FILLER), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .target_addr (target_addr),
    .pattern     (pattern),
    .mem_rvalid  (mem_rvalid),
    .idx         (idx),
    .tgt         (tgt),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .start_evt   (start_evt),
    .pat_wr_evt  (pat_wr_evt),
    .fill_wr_evt (fill_wr_evt),
    .rd_evt      (rd_evt),
    .cmp_evt     (cmp_evt),
    .busy        (busy),
    .done        (done)
  );

  dbt_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (start_evt),
    .cmp_evt       (cmp_evt),
    .fin_evt       (done),
    .tgt           (tgt),
    .expected      (pattern),
    .actual        (mem_rdata),
    .mis_evt       (mis_evt),
    .seen          (seen),
    .pass          (pass),
    .fail_addr     (fail_addr),
    .fail_expected (fail_expected),
    .fail_actual   (fail_actual)
  );

  // R6: a mismatch is only flagged on a compare
  p_mis_on_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mis_evt |-> (busy && !mem_req));

  // R4: compares happen only while no request is out
  p_cmp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |-> !mem_req);

endmodule

// File: tb/test_databus_tester.sv
module test_databus_tester;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam logic [DW-1:0] FILL = 64'h0123456789ABCDEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] target_addr = '0;
  logic mem_req, mem_we, busy, done, pass;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, fail_expected, fail_actual;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  databus_tester #(.ADDR_W(AW), .DATA_W(DW), .FILLER(FILL)) i_databus_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .target_addr(target_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr),
    .fail_expected(fail_expected), .fail_actual(fail_actual)
  );

  int checks = 0;
  int failures = 0;

  // memory model controls
  int            lat = 1;
  logic [DW-1:0] float_mask = '0;
  logic [DW-1:0] stuck1_mask = '0;

  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] last_bus = '0;
  logic [DW-1:0] pend = '0;
  int            cnt = 0;

  // request log
  logic          log_we   [0:1023];
  logic [AW-1:0] log_addr [0:1023];
  logic [DW-1:0] log_data [0:1023];
  int nreq = 0;
  int done_cnt = 0;
  int wait_viol = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (cnt > 0) begin
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pend;
      end
      cnt <= cnt - 1;
    end
    if (mem_req) begin
      if (cnt != 0 || mem_rvalid) wait_viol <= wait_viol + 1;
      log_we[nreq % 1024]   <= mem_we;
      log_addr[nreq % 1024] <= mem_addr;
      log_data[nreq % 1024] <= mem_wdata;
      nreq <= nreq + 1;
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        last_bus <= mem_wdata;
      end else begin
        pend <= ((mem[mem_addr[7:0]] & ~float_mask) | (last_bus & float_mask)) | stuck1_mask;
        cnt  <= lat;
      end
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Stimulus word n, built from run lengths rather than bit indexing.
  function automatic logic [DW-1:0] stim(input int n);
    logic [DW-1:0] v;
    int k;
    k = (n < 6) ? n : 11 - n;
    for (int b = 0; b < DW; b++) v[b] = ((b / (2 ** k)) % 2) == 1;
    if (n >= 6) v = ~v;
    return v;
  endfunction

  // Runs one test. Returns the request log base and checks busy/done timing (R8).
  task automatic run(input logic [AW-1:0] t, input bit poke_start, output int base, output int dbase);
    int guard;
    base  = nreq;
    dbase = done_cnt;
    @(negedge clk);
    target_addr = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    target_addr = ~t;             // R10: later changes must be ignored
    chk(busy === 1'b1, "R8 busy after start", {63'd0, busy}, 64'd1);
    guard = 0;
    while (done !== 1'b1 && guard < 3000) begin
      if (poke_start && guard == 20) start = 1'b1;   // R9
      if (poke_start && guard == 21) start = 1'b0;
      if (poke_start && guard == 60) start = 1'b1;
      if (poke_start && guard == 61) start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R8 done seen", {63'd0, done}, 64'd1);
    chk(busy === 1'b1, "R8 busy in done cycle", {63'd0, busy}, 64'd1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R8 done single and busy low",
        {62'd0, done, busy}, 64'd0);
  endtask

  task automatic check_sequence(input int base, input logic [AW-1:0] t, input string tag);
    int bad = 0;
    logic [AW-1:0] nb;
    nb = t + 1'b1;
    chk(nreq - base == 36, {tag, " request count"}, 64'(nreq - base), 64'd36);
    for (int i = 0; i < 12; i++) begin
      int p;
      p = (base + 3 * i) % 1024;
      if (!(log_we[p] === 1'b1 && log_addr[p] === t && log_data[p] === stim(i))) bad++;
      if (!(log_we[(p+1)%1024] === 1'b1 && log_addr[(p+1)%1024] === nb && log_data[(p+1)%1024] === FILL)) bad++;
      if (!(log_we[(p+2)%1024] === 1'b0 && log_addr[(p+2)%1024] === t)) bad++;
    end
    chk(bad == 0, {tag, " access order"}, 64'(bad), 64'd0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0 && pass === 1'b0 && mem_req === 1'b0,
        "R1 control outputs idle", {60'd0, busy, done, pass, mem_req}, 64'd0);
    chk(fail_expected === '0 && fail_actual === '0 && fail_addr === '0,
        "R1 record zero", fail_expected | fail_actual, 64'd0);
  endtask

  task automatic t_patterns();
    chk(stim(0) == 64'hAAAAAAAAAAAAAAAA, "R3 word0", stim(0), 64'hAAAAAAAAAAAAAAAA);
    chk(stim(5) == 64'hFFFFFFFF00000000, "R3 word5", stim(5), 64'hFFFFFFFF00000000);
    chk(stim(6) == 64'h00000000FFFFFFFF, "R3 word6", stim(6), 64'h00000000FFFFFFFF);
    chk(stim(11) == 64'h5555555555555555, "R3 word11", stim(11), 64'h5555555555555555);
  endtask

  task automatic t_clean(input logic [AW-1:0] t, input int l, input string tag);
    int b, d;
    lat = l; float_mask = '0; stuck1_mask = '0;
    run(t, 1'b0, b, d);
    check_sequence(b, t, {tag, " R2 R3"});
    chk(wait_viol == 0, {tag, " R4 no request while read pending"}, 64'(wait_viol), 64'd0);
    chk(pass === 1'b1, {tag, " R5 pass"}, {63'd0, pass}, 64'd1);
    chk(fail_actual === '0 && fail_expected === '0, {tag, " R7 record clear"}, fail_actual, 64'd0);
    repeat (3) @(negedge clk);
    chk(pass === 1'b1, {tag, " R5 pass held"}, {63'd0, pass}, 64'd1);
  endtask

  task automatic t_float_lane();
    int b, d;
    lat = 2; float_mask = 64'h00FF000000000000; stuck1_mask = '0;
    run(16'h0040, 1'b0, b, d);
    chk(nreq - b == 36, "R6 all words run after mismatch", 64'(nreq - b), 64'd36);
    chk(pass === 1'b0, "R6 pass low", {63'd0, pass}, 64'd0);
    chk(fail_addr === 16'h0040, "R7 fail addr", 64'(fail_addr), 64'h40);
    chk(fail_expected === 64'hAAAAAAAAAAAAAAAA, "R7 first expected kept", fail_expected, 64'hAAAAAAAAAAAAAAAA);
    chk(fail_actual === 64'hAA23AAAAAAAAAAAA, "R7 floating lane shows filler", fail_actual, 64'hAA23AAAAAAAAAAAA);
  endtask

  task automatic t_stuck();
    int b, d;
    lat = 1; float_mask = '0; stuck1_mask = 64'h8000000000000000;
    run(16'h0010, 1'b0, b, d);
    check_sequence(b, 16'h0010, "R6 stuck");
    chk(pass === 1'b0, "R6 stuck pass low", {63'd0, pass}, 64'd0);
    chk(fail_expected === 64'h00000000FFFFFFFF, "R3 R7 first failing word", fail_expected, 64'h00000000FFFFFFFF);
    chk(fail_actual === 64'h80000000FFFFFFFF, "R7 stuck actual", fail_actual, 64'h80000000FFFFFFFF);
    stuck1_mask = '0;
  endtask

  task automatic t_restart();
    t_clean(16'h0020, 1, "R7 restart");
  endtask

  task automatic t_busy_start();
    int b, d;
    lat = 3; float_mask = '0; stuck1_mask = '0;
    run(16'h0080, 1'b1, b, d);
    chk(nreq - b == 36, "R9 requests unchanged", 64'(nreq - b), 64'd36);
    chk(done_cnt - d == 1, "R9 one done", 64'(done_cnt - d), 64'd1);
    chk(pass === 1'b1, "R9 pass", {63'd0, pass}, 64'd1);
  endtask

  task automatic t_wrap();
    int b, d;
    lat = 1; float_mask = '0; stuck1_mask = '0;
    run(16'hFFFF, 1'b0, b, d);
    check_sequence(b, 16'hFFFF, "R10 wrap");
    chk(log_addr[(b + 1) % 1024] === 16'h0000, "R10 filler at zero", 64'(log_addr[(b + 1) % 1024]), 64'd0);
    chk(pass === 1'b1, "R10 pass", {63'd0, pass}, 64'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_clean(16'h0004, 1, "lat1");
    t_clean(16'h0008, 4, "lat4");
    t_float_lane();
    t_restart();
    t_stuck();
    t_busy_start();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule